// File: doc/BRIEF.md
# Syllable Fetch Sequencer

This block walks a program stored as wide words, each holding four 12-bit syllables. It keeps a program position made of a word address and a syllable index. It fetches each word through a simple synchronous memory port, then hands out the word's syllables one per cycle. The leftmost syllable comes first. After the last syllable of a word, it moves to the next word address.

Every syllable it presents is classified by its two top bits. One of four strobes is raised: operator, literal, value call or descriptor call. The low ten bits are presented alongside as the payload.

Downstream logic can stall the stream with a hold input. It can also redirect the stream with a relative branch: a signed distance counted in syllables from the syllable now on the output. A branch that stays inside the current word needs no memory access. A branch that leaves the word triggers a fetch of the target word.

Top module: `syl_seq`

## Requirements
- R1: While reset is low, `syl_valid_o` and all four strobes are low. In the first cycle after reset is released, `mem_req_o` is high with `mem_addr_o` equal to word 0, and the program position is word 0, index 0.
- R2: Memory returns the requested word in the cycle after the request. `syl_valid_o` stays low in that cycle and goes high in the cycle after it.
- R3: Within a word, syllables are issued left to right: index 0 is bits [47:36], index 1 is [35:24], index 2 is [23:12] and index 3 is [11:0]. A step without a branch moves to the next index.
- R4: Bits [11:10] of the presented syllable select the strobe: 00 operator, 01 literal, 10 value call, 11 descriptor call. Exactly one strobe is high while `syl_valid_o` is high, and none while it is low.
- R5: `payload_o` equals bits [9:0] of the presented syllable.
- R6: A branch is taken when `br_valid_i` is high, `syl_valid_o` is high and `hold_i` is low. The new position, taken as {word, index}, is the current position plus the two's-complement `br_dist_i`, modulo the whole address space.
- R7: A taken branch whose target lies in the current word presents the target syllable in the next cycle, with no memory request.
- R8: A taken branch whose target lies in another word requests that word and then presents the syllable at the target index.
- R9: While `hold_i` is high and a syllable is valid, the syllable, its strobe and the position stay unchanged in the next cycle.
- R10: `br_valid_i` has no effect while `hold_i` is high or while no syllable is valid.
- R11: A step without a branch from index 3 requests word+1, wrapping from the top word address to word 0, and resumes at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hold_i | input | 1 | Stall: freeze the current syllable |
| br_valid_i | input | 1 | Branch request for the current syllable |
| br_dist_i | input | DIST_W (10) | Signed syllable distance of the branch |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | AW (8) | Word address of the request |
| mem_rdata_i | input | SYL_W*SPW (48) | Read data, valid the cycle after the request |
| syl_valid_o | output | 1 | A syllable is presented |
| syl_o | output | SYL_W (12) | Presented syllable |
| payload_o | output | SYL_W-2 (10) | Low bits of the syllable |
| oper_stb_o | output | 1 | Operator syllable |
| lit_stb_o | output | 1 | Literal syllable |
| vcall_stb_o | output | 1 | Value call syllable |
| dcall_stb_o | output | 1 | Descriptor call syllable |
| pc_word_o | output | AW (8) | Word part of the position |
| pc_idx_o | output | log2(SPW) (2) | Syllable index of the position |

## Verification
The bench targets branches that land exactly on a word edge or cross it backwards. A design that compared only indices would then keep serving stale syllables from the old word instead of refetching. A branch of -1 from word 0, index 0 must wrap to the top word's last syllable, and a sequential step from there must wrap back to word 0. A sign-extension error sends the stream to a far, wrong word.

Branch requests are raised during hold cycles and during fetch bubbles. A design that honoured them would jump when it should stand still. In-word branches and holds are required to keep the syllable valid without a gap, so a design that needlessly refetched shows a bubble. The fetch bubble itself is counted against its two-cycle length after reset.

// File: rtl/syl_seq_pkg.sv
// Shared types for the syllable fetch sequencer.
// Assumes syllables carry their kind in the two most significant bits.
package syl_seq_pkg;

    typedef enum logic [1:0] {
        SK_OPER  = 2'b00,
        SK_LIT   = 2'b01,
        SK_VCALL = 2'b10,
        SK_DCALL = 2'b11
    } syl_kind_e;

    typedef enum logic [1:0] {
        FS_REQ  = 2'b00,
        FS_WAIT = 2'b01,
        FS_RUN  = 2'b10
    } fetch_st_e;

endpackage

// File: rtl/syl_seq_pc.sv
// Program position register: word address plus syllable index.
// Advances by one syllable or by a signed relative distance when stepped.
// Assumes SPW is a power of two, so the index wraps into the word part.
module syl_seq_pc #(
    parameter int AW         = 8,
    parameter int IDX_W      = 2,
    parameter int DIST_W     = 10,
    parameter int RESET_WORD = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              br_i,
    input  logic [DIST_W-1:0] dist_i,
    output logic [AW-1:0]     word_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              word_chg_o
);
    localparam int PCW   = AW + IDX_W;
    localparam int EXT_W = (PCW > DIST_W) ? PCW : DIST_W;
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    logic [PCW-1:0]   pc_q;
    logic [PCW-1:0]   pc_nxt;
    logic [EXT_W-1:0] dist_ext;
    logic [EXT_W-1:0] pc_ext;

    assign dist_ext = EXT_W'($signed(dist_i));
    assign pc_ext   = EXT_W'(pc_q);

    // Next position: relative branch target or the following syllable.
    always_comb begin
        if (br_i) begin
            pc_nxt = PCW'(pc_ext + dist_ext);
        end else begin
            pc_nxt = pc_q + PCW'(1);
        end
    end

    assign word_chg_o = (pc_nxt[PCW-1:IDX_W] != pc_q[PCW-1:IDX_W]);
    assign word_o     = pc_q[PCW-1:IDX_W];
    assign idx_o      = pc_q[IDX_W-1:0];

    // Position register, loaded only when a syllable is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= {AW'(RESET_WORD), {IDX_W{1'b0}}};
        end else if (step_i) begin
            pc_q <= pc_nxt;
        end
    end

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !br_i && idx_o != LAST_IDX)
            |=> (idx_o == $past(idx_o) + IDX_W'(1)) && (word_o == $past(word_o)))
        else $error("sequential step did not move to next index");

    assert_word_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !br_i && idx_o == LAST_IDX)
            |=> (word_o == $past(word_o) + AW'(1)) && (idx_o == '0))
        else $error("last syllable did not advance to next word");

endmodule

// File: rtl/syl_seq_fetch.sv
// Word fetch control: requests a word, captures it one cycle later and
// marks the stream valid until a step leaves the current word.
// Assumes the memory answers every request in exactly the next cycle.
module syl_seq_fetch
    import syl_seq_pkg::*;
#(
    parameter int WORD_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              word_chg_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              mem_req_o,
    output logic              run_o,
    output logic [WORD_W-1:0] word_o
);
    fetch_st_e st_q;
    fetch_st_e st_nxt;

    // Next fetch state.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            FS_REQ:  st_nxt = FS_WAIT;
            FS_WAIT: st_nxt = FS_RUN;
            FS_RUN:  if (step_i && word_chg_i) st_nxt = FS_REQ;
            default: st_nxt = FS_REQ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= FS_REQ;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Word buffer, filled in the cycle the memory data is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (st_q == FS_WAIT) begin
            word_o <= mem_rdata_i;
        end
    end

    assign mem_req_o = (st_q == FS_REQ);
    assign run_o     = (st_q == FS_RUN);

    assert_fetch_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !run_o)
        else $error("stream valid in the data-return cycle");

    assert_req_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o)
        else $error("request held for more than one cycle");

endmodule

// File: rtl/syl_seq_decode.sv
// Selects the indexed syllable from the buffered word and classifies it.
// Index 0 is the leftmost (most significant) syllable.
// Strobes are qualified by the valid input.
module syl_seq_decode
    import syl_seq_pkg::*;
#(
    parameter int SYL_W = 12,
    parameter int SPW   = 4,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SYL_W*SPW-1:0] word_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic                 valid_i,
    output logic [SYL_W-1:0]     syl_o,
    output logic [SYL_W-3:0]     payload_o,
    output logic                 oper_stb_o,
    output logic                 lit_stb_o,
    output logic                 vcall_stb_o,
    output logic                 dcall_stb_o
);
    logic [SYL_W-1:0] slot [SPW];
    syl_kind_e        kind;

    for (genvar g = 0; g < SPW; g++) begin : g_slot
        assign slot[g] = word_i[SYL_W*(SPW-g)-1 -: SYL_W];
    end

    assign syl_o     = slot[idx_i];
    assign payload_o = syl_o[SYL_W-3:0];
    assign kind      = syl_kind_e'(syl_o[SYL_W-1 -: 2]);

    // One strobe per syllable kind, only while a syllable is valid.
    always_comb begin
        oper_stb_o  = 1'b0;
        lit_stb_o   = 1'b0;
        vcall_stb_o = 1'b0;
        dcall_stb_o = 1'b0;
        if (valid_i) begin
            unique case (kind)
                SK_OPER:  oper_stb_o  = 1'b1;
                SK_LIT:   lit_stb_o   = 1'b1;
                SK_VCALL: vcall_stb_o = 1'b1;
                SK_DCALL: dcall_stb_o = 1'b1;
                default:  oper_stb_o  = 1'b0;
            endcase
        end
    end

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> $countones({oper_stb_o, lit_stb_o, vcall_stb_o, dcall_stb_o}) == 1)
        else $error("valid syllable without exactly one strobe");

    assert_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> !(oper_stb_o || lit_stb_o || vcall_stb_o || dcall_stb_o))
        else $error("strobe without a valid syllable");

endmodule

// File: rtl/syl_seq.sv
// Top of the syllable fetch sequencer: ties the position register, the
// fetch control and the decoder together. Hold freezes the stream; a branch
// is honoured only on a valid, unheld syllable.
module syl_seq #(
    parameter int AW     = 8,
    parameter int SYL_W  = 12,
    parameter int SPW    = 4,
    parameter int DIST_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hold_i,
    input  logic                       br_valid_i,
    input  logic [DIST_W-1:0]          br_dist_i,
    output logic                       mem_req_o,
    output logic [AW-1:0]              mem_addr_o,
    input  logic [SYL_W*SPW-1:0]       mem_rdata_i,
    output logic                       syl_valid_o,
    output logic [SYL_W-1:0]           syl_o,
    output logic [SYL_W-3:0]           payload_o,
    output logic                       oper_stb_o,
    output logic                       lit_stb_o,
    output logic                       vcall_stb_o,
    output logic                       dcall_stb_o,
    output logic [AW-1:0]              pc_word_o,
    output logic [$clog2(SPW)-1:0]     pc_idx_o
);
    localparam int IDX_W  = $clog2(SPW);
    localparam int WORD_W = SYL_W * SPW;

    logic              run;
    logic              step;
    logic              br_take;
    logic              word_chg;
    logic [WORD_W-1:0] word_buf;

    assign step    = run && !hold_i;
    assign br_take = step && br_valid_i;

    syl_seq_pc #(
        .AW(AW), .IDX_W(IDX_W), .DIST_W(DIST_W), .RESET_WORD(0)
    ) u_pc (
        .clk(clk), .rst_n(rst_n), .step_i(step), .br_i(br_take),
        .dist_i(br_dist_i), .word_o(pc_word_o), .idx_o(pc_idx_o),
        .word_chg_o(word_chg)
    );

    syl_seq_fetch #(
        .WORD_W(WORD_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .step_i(step), .word_chg_i(word_chg),
        .mem_rdata_i(mem_rdata_i), .mem_req_o(mem_req_o), .run_o(run),
        .word_o(word_buf)
    );

    syl_seq_decode #(
        .SYL_W(SYL_W), .SPW(SPW), .IDX_W(IDX_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .word_i(word_buf), .idx_i(pc_idx_o),
        .valid_i(run), .syl_o(syl_o), .payload_o(payload_o),
        .oper_stb_o(oper_stb_o), .lit_stb_o(lit_stb_o),
        .vcall_stb_o(vcall_stb_o), .dcall_stb_o(dcall_stb_o)
    );

    assign syl_valid_o = run;
    assign mem_addr_o  = pc_word_o;

    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (syl_valid_o && hold_i)
            |=> syl_valid_o && $stable(syl_o) && $stable(pc_word_o) && $stable(pc_idx_o))
        else $error("held syllable changed");

    assert_inword_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_take && !word_chg) |=> syl_valid_o && !mem_req_o)
        else $error("in-word branch caused a bubble");

    assert_far_branch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_take && word_chg) |=> mem_req_o && !syl_valid_o)
        else $error("word-changing branch did not refetch");

endmodule

// File: tb/syl_seq_tb.sv
module syl_seq_tb;
    localparam int AW     = 8;
    localparam int SYL_W  = 12;
    localparam int SPW    = 4;
    localparam int DIST_W = 10;
    localparam int WORD_W = SYL_W * SPW;
    localparam int SPACE  = (1 << AW) * SPW;
    localparam int NSTEP  = 20;

    // Each entry: {hold, branch, distance[9:0]}
    localparam logic [11:0] STEPS [NSTEP] = '{
        {2'b00, 10'd0},   {2'b00, 10'd0},   {2'b10, 10'd0},   {2'b10, 10'd0},
        {2'b00, 10'd0},   {2'b00, 10'd0},   {2'b01, 10'd2},   {2'b01, 10'd0},
        {2'b01, 10'h3FD}, {2'b01, 10'd9},   {2'b11, 10'd5},   {2'b00, 10'd0},
        {2'b01, 10'h3F3}, {2'b01, 10'h3FF}, {2'b00, 10'd0},   {2'b01, 10'd1},
        {2'b00, 10'd0},   {2'b01, 10'h3FE}, {2'b00, 10'd0},   {2'b10, 10'd0}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                rst_n      = 1'b0;
    logic                hold_i     = 1'b0;
    logic                br_valid_i = 1'b0;
    logic [DIST_W-1:0]   br_dist_i  = '0;
    logic [WORD_W-1:0]   mem_rdata_i = '0;
    logic                mem_req_o;
    logic [AW-1:0]       mem_addr_o;
    logic                syl_valid_o;
    logic [SYL_W-1:0]    syl_o;
    logic [SYL_W-3:0]    payload_o;
    logic                oper_stb_o, lit_stb_o, vcall_stb_o, dcall_stb_o;
    logic [AW-1:0]       pc_word_o;
    logic [1:0]          pc_idx_o;

    int n_chk  = 0;
    int n_fail = 0;
    int spc    = 0;

    syl_seq #(.AW(AW), .SYL_W(SYL_W), .SPW(SPW), .DIST_W(DIST_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .br_valid_i(br_valid_i),
        .br_dist_i(br_dist_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .syl_valid_o(syl_valid_o), .syl_o(syl_o),
        .payload_o(payload_o), .oper_stb_o(oper_stb_o), .lit_stb_o(lit_stb_o),
        .vcall_stb_o(vcall_stb_o), .dcall_stb_o(dcall_stb_o),
        .pc_word_o(pc_word_o), .pc_idx_o(pc_idx_o)
    );

    function automatic logic [11:0] ref_syl(input int s);
        int w = s >> 2;
        int k = s & 3;
        return {2'((w + k) & 3), 10'(((w * 4 + k) * 37) & 1023)};
    endfunction

    function automatic logic [WORD_W-1:0] ref_word(input int w);
        logic [WORD_W-1:0] r = '0;
        for (int k = 0; k < SPW; k++) r[WORD_W-1-12*k -: 12] = ref_syl(w * 4 + k);
        return r;
    endfunction

    // Memory model: one cycle of read latency.
    always @(posedge clk) if (mem_req_o) mem_rdata_i <= ref_word(int'(mem_addr_o));

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {oper_stb_o, lit_stb_o, vcall_stb_o, dcall_stb_o};
    endfunction

    // Reset and first-fetch timing: R1, R2
    task automatic reset_seq();
        @(negedge clk);
        rst_n = 1'b0; hold_i = 1'b0; br_valid_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!syl_valid_o && strobes() == 4'b0, "R1", "outputs in reset",
            int'({syl_valid_o, strobes()}), 0);
        rst_n = 1'b1;
        #1;
        chk(mem_req_o && mem_addr_o == '0, "R1", "first request to word 0",
            int'(mem_addr_o) + (mem_req_o ? 0 : 1000), 0);
        chk(!syl_valid_o, "R2", "valid in request cycle", int'(syl_valid_o), 0);
        @(negedge clk);
        chk(!syl_valid_o && !mem_req_o, "R2", "data-return cycle quiet",
            int'({syl_valid_o, mem_req_o}), 0);
        @(negedge clk);
        chk(syl_valid_o && syl_o == ref_syl(0), "R2", "first syllable",
            int'(syl_o), int'(ref_syl(0)));
        spc = 0;
    endtask

    initial begin
        string tag  = "R3";
        bit    imm  = 1'b1;
        reset_seq();
        for (int i = 0; i < NSTEP; i++) begin
            logic        h, b;
            logic [9:0]  d;
            logic [11:0] es;
            int          nspc;
            if (imm) chk(syl_valid_o, tag, "no bubble expected", int'(syl_valid_o), 1);
            while (!syl_valid_o) begin
                if (mem_req_o)
                    chk(int'(mem_addr_o) == (spc >> 2), tag, "R8 R11 fetch address",
                        int'(mem_addr_o), spc >> 2);
                // R10: branch during a bubble must be ignored
                br_valid_i = 1'b1;
                br_dist_i  = 10'd7;
                @(negedge clk);
            end
            br_valid_i = 1'b0;
            es = ref_syl(spc);
            chk(syl_o == es, tag, "syllable", int'(syl_o), int'(es));
            chk(payload_o == es[9:0], "R5", "payload", int'(payload_o), int'(es[9:0]));
            chk(strobes() == (4'b1000 >> es[11:10]), "R4", "strobe",
                int'(strobes()), int'(4'b1000 >> es[11:10]));
            chk({pc_word_o, pc_idx_o} == 10'(spc), "R6", "position",
                int'({pc_word_o, pc_idx_o}), spc);
            {h, b, d} = STEPS[i];
            hold_i = h; br_valid_i = b; br_dist_i = d;
            @(negedge clk);
            hold_i = 1'b0; br_valid_i = 1'b0;
            if (h && b) begin
                tag = "R10"; imm = 1'b1;
            end else if (h) begin
                tag = "R9"; imm = 1'b1;
            end else if (b) begin
                nspc = (((spc + int'($signed(d))) % SPACE) + SPACE) % SPACE;
                imm  = ((nspc >> 2) == (spc >> 2));
                tag  = imm ? "R7" : "R8";
                spc  = nspc;
            end else begin
                nspc = (spc + 1) % SPACE;
                imm  = ((nspc >> 2) == (spc >> 2));
                tag  = imm ? "R3" : "R11";
                spc  = nspc;
            end
        end
        // Reset in the middle of a run
        reset_seq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule